// File: doc/BRIEF.md
# Codec Control Register Shadow and Write Formatter

This block sits between a host and a two-byte serial control bus to an audio codec. The codec's control registers cannot be read, so the block keeps a shadow copy of every register. Each accepted host write is packed into a 16-bit control word. The upper 7 bits carry the register address and the lower 9 bits carry the value. The word is handed to a downstream bus master as a high byte and a low byte, together with a fixed device address. The downstream side uses a valid/ready request followed by a done pulse.

A host write is either cached or uncached. A cached write sends the word and also records the value in the shadow. An uncached write sends the word and leaves the shadow alone. This lets a driver store a channel level and then pulse the latch bit (value bit 8) without that bit staying in the copy. Reads never cause bus traffic. A read returns the shadow entry one cycle later.

Top module: `codec_shadow_writer`

## Requirements
- R1: After reset, busy, tx_valid and rd_valid are low, wr_ready is high, and every shadow entry reads as 0x0000.
- R2: For an accepted write, tx_hi equals {addr[6:0], value[8]}, tx_lo equals value[7:0], and tx_dev is always 0x34.
- R3: A write to an address above 0x17 is accepted but ignored. No transfer starts, busy stays low and no shadow entry changes.
- R4: A cached write (wr_nocache=0) to an address in 0x00..0x17 stores the 9-bit value. Later reads of that address return it zero-extended to 16 bits.
- R5: An uncached write (wr_nocache=1) starts a transfer but leaves the shadow entry unchanged.
- R6: busy rises in the cycle after a write is accepted and falls in the cycle after tx_done. wr_ready is the inverse of busy, and writes presented while busy are dropped.
- R7: tx_valid is high only while busy, and it stays high with stable bytes until tx_ready. After tx_ready the block waits for tx_done.
- R8: rd_valid pulses in the cycle after rd_en, and rd_data then holds the addressed entry. Addresses above 0x17 read as 0x0000.
- R9: When a cached write and a read of the same address fall in one cycle, the read returns the value held before that write.
- R10: A cached write of a level followed by an uncached write of the same level with bit 8 set produces two transfers. The shadow afterwards holds the level with bit 8 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_addr | input | 7 | Register address of the write |
| wr_data | input | 9 | Register value of the write |
| wr_nocache | input | 1 | 1 sends the word without updating the shadow |
| wr_ready | output | 1 | High when a write can be accepted |
| rd_en | input | 1 | Shadow read request |
| rd_addr | input | 7 | Register address of the read |
| rd_valid | output | 1 | Read result is valid |
| rd_data | output | 16 | Zero-extended shadow value |
| tx_valid | output | 1 | Byte-pair transfer request |
| tx_dev | output | 8 | Device address of the transfer |
| tx_hi | output | 8 | First byte sent |
| tx_lo | output | 8 | Second byte sent |
| tx_ready | input | 1 | Downstream accepted the request |
| tx_done | input | 1 | Downstream finished the transfer |
| busy | output | 1 | A transfer is in flight |

## Verification
A shadow read and a cached write can land on the same register in the same cycle. The bench provokes this by raising rd_en and wr_valid together for one address that already holds a known value. It then judges the read result against the old value and confirms the new value with a follow-up read. A host write can also arrive while a transfer is still stalled on tx_ready or tx_done. The bench holds wr_valid across the busy window under varied downstream delays. A reference model updated on every clock must agree that only the first write produced a transfer.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_REQ  = 2'd1,
        TX_WAIT = 2'd2
    } tx_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/csw_word_fmt.sv
`timescale 1ns/1ps
module csw_word_fmt #(
    parameter int ADDR_W   = 7,
    parameter int VAL_W    = 9,
    parameter int NUM_REGS = 24,
    localparam int WORD_W  = ADDR_W + VAL_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [VAL_W-1:0]  value,
    output logic              in_range,
    output logic [IDX_W-1:0]  idx,
    output logic [7:0]        byte_hi,
    output logic [7:0]        byte_lo
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    logic [WORD_W-1:0] word;

    always_comb begin
        word     = {addr, value};
        in_range = (addr <= LAST_ADDR);
        idx      = addr[IDX_W-1:0];
        byte_hi  = word[WORD_W-1 -: 8];
        byte_lo  = word[7:0];
    end
endmodule

// File: rtl/csw_shadow_bank.sv
`timescale 1ns/1ps
module csw_shadow_bank #(
    parameter int VAL_W    = 9,
    parameter int NUM_REGS = 24,
    parameter int RD_W     = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VAL_W-1:0] wr_val,
    input  logic             rd_en,
    input  logic             rd_hit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [RD_W-1:0]  rd_data
);
    typedef struct packed {
        logic [NUM_REGS-1:0][VAL_W-1:0] ent;
        logic                           rd_vld;
        logic [RD_W-1:0]                rd_dat;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_REGS-1:0] sel;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_comb begin
        bank_d        = bank_q;
        bank_d.rd_vld = rd_en;
        if (rd_en) begin
            if (rd_hit) begin
                bank_d.rd_dat = {{(RD_W-VAL_W){1'b0}}, bank_q.ent[rd_idx]};
            end else begin
                bank_d.rd_dat = '0;
            end
        end
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                bank_d.ent[i] = wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_valid = bank_q.rd_vld;
    assign rd_data  = bank_q.rd_dat;
endmodule

// File: rtl/csw_tx_ctrl.sv
`timescale 1ns/1ps
module csw_tx_ctrl
    import csw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] hi_in,
    input  logic [7:0] lo_in,
    input  logic       tx_ready,
    input  logic       tx_done,
    output logic       tx_valid,
    output logic [7:0] tx_hi,
    output logic [7:0] tx_lo,
    output logic       busy
);
    typedef struct packed {
        tx_state_e  st;
        logic [7:0] hi;
        logic [7:0] lo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            TX_IDLE: begin
                if (start) begin
                    ctl_d.st = TX_REQ;
                    ctl_d.hi = hi_in;
                    ctl_d.lo = lo_in;
                end
            end
            TX_REQ: begin
                if (tx_ready) begin
                    ctl_d.st = TX_WAIT;
                end
            end
            TX_WAIT: begin
                if (tx_done) begin
                    ctl_d.st = TX_IDLE;
                end
            end
            default: ctl_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: TX_IDLE, hi: 8'h00, lo: 8'h00};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_valid = (ctl_q.st == TX_REQ);
    assign tx_hi    = ctl_q.hi;
    assign tx_lo    = ctl_q.lo;
    assign busy     = (ctl_q.st != TX_IDLE);
endmodule

// File: rtl/codec_shadow_writer.sv
`timescale 1ns/1ps
module codec_shadow_writer #(
    parameter int          ADDR_W   = 7,
    parameter int          VAL_W    = 9,
    parameter int          NUM_REGS = 24,
    parameter logic [7:0]  DEV_ADDR = 8'h34,
    localparam int         RD_W     = ADDR_W + VAL_W,
    localparam int         IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VAL_W-1:0]  wr_data,
    input  logic              wr_nocache,
    output logic              wr_ready,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [RD_W-1:0]   rd_data,
    output logic              tx_valid,
    output logic [7:0]        tx_dev,
    output logic [7:0]        tx_hi,
    output logic [7:0]        tx_lo,
    input  logic              tx_ready,
    input  logic              tx_done,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    logic             wr_in_range;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       fmt_hi;
    logic [7:0]       fmt_lo;
    logic             accept;
    logic             start;
    logic             rd_hit;

    csw_word_fmt #(
        .ADDR_W   (ADDR_W),
        .VAL_W    (VAL_W),
        .NUM_REGS (NUM_REGS)
    ) u_fmt (
        .addr     (wr_addr),
        .value    (wr_data),
        .in_range (wr_in_range),
        .idx      (wr_idx),
        .byte_hi  (fmt_hi),
        .byte_lo  (fmt_lo)
    );

    assign wr_ready = !busy;
    assign accept   = wr_valid && wr_ready;
    assign start    = accept && wr_in_range;
    assign rd_hit   = (rd_addr <= LAST_ADDR);

    csw_tx_ctrl u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .hi_in    (fmt_hi),
        .lo_in    (fmt_lo),
        .tx_ready (tx_ready),
        .tx_done  (tx_done),
        .tx_valid (tx_valid),
        .tx_hi    (tx_hi),
        .tx_lo    (tx_lo),
        .busy     (busy)
    );

    csw_shadow_bank #(
        .VAL_W    (VAL_W),
        .NUM_REGS (NUM_REGS),
        .RD_W     (RD_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (start && !wr_nocache),
        .wr_idx   (wr_idx),
        .wr_val   (wr_data),
        .rd_en    (rd_en),
        .rd_hit   (rd_hit),
        .rd_idx   (rd_addr[IDX_W-1:0]),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign tx_dev = DEV_ADDR;
endmodule

// File: rtl/csw_checker.sv
`timescale 1ns/1ps
module csw_checker #(
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 24,
    parameter int RD_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_ready,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [RD_W-1:0]   rd_data,
    input logic              tx_valid,
    input logic [7:0]        tx_dev,
    input logic [7:0]        tx_hi,
    input logic [7:0]        tx_lo,
    input logic              tx_ready,
    input logic              tx_done,
    input logic              busy
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    assert_dev_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_dev == 8'h34);

    assert_drop_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_addr > LAST_ADDR) |=> (!busy && !tx_valid));

    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_addr <= LAST_ADDR) |=> (busy && tx_valid));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_valid && tx_done) |=> !busy);

    assert_valid_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_hi) && $stable(tx_lo)));

    assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_oob_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr > LAST_ADDR) |=> rd_data == '0);
endmodule

bind codec_shadow_writer csw_checker #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .RD_W     (RD_W)
) u_csw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_ready (wr_ready),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .tx_valid (tx_valid),
    .tx_dev   (tx_dev),
    .tx_hi    (tx_hi),
    .tx_lo    (tx_lo),
    .tx_ready (tx_ready),
    .tx_done  (tx_done),
    .busy     (busy)
);

// File: tb/tb_codec_shadow_writer.sv
`timescale 1ns/1ps
module tb_codec_shadow_writer;
    localparam int NR = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [8:0]  wr_data = '0;
    logic        wr_nocache = 1'b0;
    logic        wr_ready;
    logic        rd_en = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        tx_valid;
    logic [7:0]  tx_dev;
    logic [7:0]  tx_hi;
    logic [7:0]  tx_lo;
    logic        tx_ready = 1'b0;
    logic        tx_done = 1'b0;
    logic        busy;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int tx_count = 0;

    always #5 clk = ~clk;

    codec_shadow_writer dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_nocache(wr_nocache), .wr_ready(wr_ready),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_dev(tx_dev), .tx_hi(tx_hi), .tx_lo(tx_lo),
        .tx_ready(tx_ready), .tx_done(tx_done), .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: integers and an int array, updated per clock.
    int m_shadow [NR];
    int m_state;
    int m_hi, m_lo;
    int m_rd_valid, m_rd_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_shadow[i]) m_shadow[i] = 0;
            m_state = 0; m_hi = 0; m_lo = 0; m_rd_valid = 0; m_rd_data = 0;
        end else begin
            m_rd_valid = int'(rd_en);
            if (rd_en) m_rd_data = (int'(rd_addr) < NR) ? m_shadow[int'(rd_addr)] : 0;
            case (m_state)
                0: if (wr_valid && int'(wr_addr) < NR) begin
                    m_state = 1;
                    m_hi = (int'(wr_addr) << 1) | int'(wr_data[8]);
                    m_lo = int'(wr_data[7:0]);
                    if (!wr_nocache) m_shadow[int'(wr_addr)] = int'(wr_data);
                end
                1: if (tx_ready) m_state = 2;
                default: if (tx_done) m_state = 0;
            endcase
        end
    end

    // Compare every clock, 2 ns after the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R6", "busy", int'(busy), int'(m_state != 0));
            chk("R6", "wr_ready", int'(wr_ready), int'(m_state == 0));
            chk("R7", "tx_valid", int'(tx_valid), int'(m_state == 1));
            chk("R2", "tx_dev", int'(tx_dev), 'h34);
            if (m_state == 1) begin
                chk("R2", "tx_hi", int'(tx_hi), m_hi);
                chk("R2", "tx_lo", int'(tx_lo), m_lo);
            end
            chk("R8", "rd_valid", int'(rd_valid), m_rd_valid);
            if (m_rd_valid != 0) chk("R4", "rd_data", int'(rd_data), m_rd_data);
        end
    end

    // Downstream responder with programmable delays.
    int ready_delay = 0;
    int done_delay = 0;
    int rphase = 0;
    int rcnt = 0;
    always @(negedge clk) begin
        tx_ready = 1'b0;
        tx_done  = 1'b0;
        if (rst_n) begin
            if (rphase == 0) begin
                if (tx_valid) begin
                    if (rcnt >= ready_delay) begin
                        tx_ready = 1'b1; rphase = 1; rcnt = 0; tx_count++;
                    end else rcnt++;
                end
            end else begin
                if (rcnt >= done_delay) begin
                    tx_done = 1'b1; rphase = 0; rcnt = 0;
                end else rcnt++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_write(input int a, input int d, input bit nc);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 7'(a); wr_data = 9'(d); wr_nocache = nc;
        @(negedge clk);
        wr_valid = 1'b0;
        wait_idle();
    endtask

    task automatic do_read(input int a, input string req, input int exp);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 7'(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, "rd_valid", int'(rd_valid), 1);
        chk(req, "rd_data", int'(rd_data), exp);
    endtask

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "tx_valid", int'(tx_valid), 0);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "wr_ready", int'(wr_ready), 1);
        for (int a = 0; a < NR; a++) do_read(a, "R1", 0);

        // R2, R4: cached write, quick responder
        n0 = tx_count;
        do_write(3, 'h0AB, 1'b0);
        chk("R2", "transfers", tx_count - n0, 1);
        do_read(3, "R4", 'h00AB);

        // R10, R5: uncached latch write with bit 8
        n0 = tx_count;
        do_write(3, 'h1AB, 1'b1);
        chk("R10", "transfers", tx_count - n0, 1);
        do_read(3, "R5", 'h00AB);
        do_write(4, 'h0C0, 1'b0);
        do_write(4, 'h1C0, 1'b1);
        do_read(4, "R10", 'h00C0);

        // R3: out-of-range writes ignored
        n0 = tx_count;
        do_write('h18, 'h155, 1'b0);
        do_write('h7F, 'h0FF, 1'b0);
        repeat (4) @(negedge clk);
        chk("R3", "transfers", tx_count - n0, 0);
        chk("R3", "busy", int'(busy), 0);
        do_read('h18, "R8", 0);
        do_read('h7F, "R8", 0);
        do_read(0, "R3", 0);

        // R6, R7: stalled downstream, write held across busy window
        ready_delay = 3; done_delay = 4;
        n0 = tx_count;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 7'd7; wr_data = 9'h123; wr_nocache = 1'b0;
        @(negedge clk);
        wr_addr = 7'd8; wr_data = 9'h0EE;
        repeat (6) @(negedge clk);
        wr_valid = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R6", "transfers", tx_count - n0, 1);
        do_read(7, "R6", 'h0123);
        do_read(8, "R6", 0);

        // R9: same-cycle cached write and read of one address
        ready_delay = 0; done_delay = 1;
        do_write(5, 'h055, 1'b0);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 7'd5; wr_data = 9'h1FF; wr_nocache = 1'b0;
        rd_en = 1'b1; rd_addr = 7'd5;
        @(negedge clk);
        wr_valid = 1'b0; rd_en = 1'b0;
        chk("R9", "rd_data", int'(rd_data), 'h0055);
        wait_idle();
        do_read(5, "R9", 'h01FF);

        // R4: fill every entry under varied delays, then read back
        for (int a = 0; a < NR; a++) begin
            ready_delay = a % 3; done_delay = (a * 5) % 4;
            do_write(a, (a * 37 + 11) % 512, 1'b0);
        end
        for (int a = 0; a < NR; a++) do_read(a, "R4", (a * 37 + 11) % 512);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule